// File: doc/BRIEF.md
# Descriptor Sync Flag Gate

This block orders work among several DMA channels through one shared 8-bit sync flag held outside the block. Each channel receives a 32-bit sync control word when its descriptor is loaded. The block compares the control word with the flag and holds back the channel's start until the flag allows it. When the channel reports that its operation has finished, the block writes a new flag value. A fixed-priority grant lets only one channel write the flag in any cycle. The read, the compare and the write for that channel all happen in its granted cycle.

A second mode exists for channels that only signal one another. In that mode no flash operation runs. The block compares the flag in the granted cycle and always increments it. It also raises a skip-flash strobe and an interrupt for the channel when the compare succeeds.

Top module: `sync_flag_gate`

## Requirements
- R1: The control word fields are: bit 0 inc (post-operation increment), bit 1 ahead-compare, bit 2 valid, bit 4 sync-interrupt mode, bits 23:16 end value, bits 31:24 start value. Bits 3 and 15:5 are reserved and have no effect on behaviour.
- R2: With valid set, ahead-compare clear and sync-interrupt clear, `start` for the channel is high only while the flag equals the start value.
- R3: With valid set, ahead-compare set and sync-interrupt clear, `start` is high only while (flag − start value) mod 256 is below 128.
- R4: While a loaded descriptor's compare fails, `start` stays low and the compare is repeated every cycle. `start` goes high in the first cycle the flag satisfies it, and it is a single-cycle pulse.
- R5: After `done` for a valid, non-sync descriptor, the channel makes one flag write. The data is flag+1 (mod 256) when inc is set, and the end value otherwise. The write occurs in the cycle `upd_done` is high.
- R6: With valid clear, `start` rises one cycle after the load whatever the flag is. No flag write follows `done`, and the sync-interrupt bit is ignored.
- R7: With valid and sync-interrupt set, `start` never rises. In the granted cycle the flag is written with flag+1. `irq` and `skip` go high in that cycle only if (flag − start value) mod 256 is below 128.
- R8: In sync-interrupt mode the actual ahead-compare and inc bits have no effect. The write is always flag+1 and never the end value.
- R9: At most one channel writes the flag in a cycle, and the lowest-numbered requesting channel wins. A channel that waits reads the flag value written by the channel before it.
- R10: A `load` pulse to a channel that is not idle is ignored.
- R11: During and immediately after reset every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | NCH | Per-channel descriptor load strobe |
| ctl | input | 32*NCH | Per-channel sync control words, channel i at bits 32i+31:32i |
| done | input | NCH | Per-channel operation finished |
| flag_rd | input | 8 | Current value of the shared sync flag |
| flag_wr_en | output | 1 | Flag write strobe |
| flag_wr_data | output | 8 | New flag value |
| start | output | NCH | Descriptor may start (one-cycle pulse) |
| skip | output | NCH | Flash command to be skipped |
| irq | output | NCH | Channel interrupt from sync-interrupt mode |
| upd_done | output | NCH | Channel's flag update performed this cycle |

## Verification
The assertions check the following on every cycle: only one channel writes the flag at a time; an interrupt always comes with that channel's own update and with flag+1 on the write port; skip never appears without a write; `start` is a single-cycle pulse that never coincides with an update. The compare arithmetic cannot be seen that way, so the bench's sweeps show it. These sweeps cover the exact compare, the wraparound ahead compare near the 128 boundary and the end value versus increment choice. They also cover the priority order when two channels wait together, the load that is ignored while a channel is busy, and the fields with no effect.

// File: rtl/sync_flag_gate.sv
`timescale 1ns/1ps
module sync_flag_gate #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   load,
  input  logic [NCH*32-1:0] ctl,
  input  logic [NCH-1:0]   done,
  input  logic [7:0]       flag_rd,
  output logic             flag_wr_en,
  output logic [7:0]       flag_wr_data,
  output logic [NCH-1:0]   start,
  output logic [NCH-1:0]   skip,
  output logic [NCH-1:0]   irq,
  output logic [NCH-1:0]   upd_done
);
  localparam int FW = 8;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RUN, S_UPD, S_SYNC} st_t;

  logic [NCH-1:0] req, gnt;
  logic [FW-1:0]  wdat [NCH];

  assign gnt        = req & (~req + NCH'(1));
  assign flag_wr_en = |gnt;
  assign upd_done   = gnt;

  always_comb begin
    flag_wr_data = '0;
    for (int i = 0; i < NCH; i++)
      if (gnt[i]) flag_wr_data = flag_wr_data | wdat[i];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    st_t         st;
    logic [31:0] cw;
    logic [FW-1:0] sv, ev, diff;
    logic inc, grt, vld, sint, ahead, pass;

    assign inc  = cw[0];
    assign grt  = cw[1];
    assign vld  = cw[2];
    assign sint = cw[4];
    assign ev   = cw[23:16];
    assign sv   = cw[31:24];

    assign diff  = flag_rd - sv;
    assign ahead = ~diff[FW-1];
    assign pass  = ~vld | (grt ? ahead : (diff == '0));

    assign req[i]   = (st == S_UPD) | (st == S_SYNC);
    assign start[i] = (st == S_WAIT) & pass;
    assign irq[i]   = gnt[i] & (st == S_SYNC) & ahead;
    assign skip[i]  = irq[i];
    assign wdat[i]  = (st == S_SYNC || inc) ? flag_rd + FW'(1) : ev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= S_IDLE;
        cw <= '0;
      end else begin
        case (st)
          S_IDLE: if (load[i]) begin
            cw <= ctl[i*32 +: 32];
            st <= (ctl[i*32+2] && ctl[i*32+4]) ? S_SYNC : S_WAIT;
          end
          S_WAIT: if (pass) st <= S_RUN;
          S_RUN:  if (done[i]) st <= vld ? S_UPD : S_IDLE;
          S_UPD, S_SYNC: if (gnt[i]) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sync_flag_gate_sva.sv
`timescale 1ns/1ps
module sync_flag_gate_sva #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     flag_rd,
  input logic           flag_wr_en,
  input logic [7:0]     flag_wr_data,
  input logic [NCH-1:0] start,
  input logic [NCH-1:0] skip,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] upd_done
);
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_en |-> $onehot(upd_done)) else $error("one writer"); // R9

  AST_UPD_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done != '0) |-> flag_wr_en) else $error("upd without write"); // R5

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_IRQ_INCR: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (upd_done[i] && flag_wr_data == 8'(flag_rd + 8'd1))) else $error("irq incr"); // R7
    AST_SKIP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      skip[i] |-> flag_wr_en) else $error("skip write"); // R7
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] |=> !start[i]) else $error("start pulse"); // R4
    AST_START_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] |-> !upd_done[i]) else $error("start with update"); // R4
  end
endmodule

bind sync_flag_gate sync_flag_gate_sva #(.NCH(NCH)) u_sva (
  .clk(clk), .rst_n(rst_n), .flag_rd(flag_rd), .flag_wr_en(flag_wr_en),
  .flag_wr_data(flag_wr_data), .start(start), .skip(skip), .irq(irq),
  .upd_done(upd_done)
);

// File: tb/sync_flag_gate_tb.sv
`timescale 1ns/1ps
module sync_flag_gate_tb;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] load = '0, done = '0;
  logic [NCH*32-1:0] ctl = '0;
  logic [7:0] flag = '0, set_val = '0;
  logic set_en = 0;
  logic flag_wr_en;
  logic [7:0] flag_wr_data;
  logic [NCH-1:0] start, skip, irq, upd_done;
  int n_chk = 0, n_err = 0, n_wr = 0;

  always #4 clk = ~clk;

  sync_flag_gate #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .ctl(ctl), .done(done),
    .flag_rd(flag), .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .start(start), .skip(skip), .irq(irq), .upd_done(upd_done));

  always @(posedge clk) begin
    if (set_en) flag <= set_val;
    else if (flag_wr_en) flag <= flag_wr_data;
    if (flag_wr_en) n_wr <= n_wr + 1;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] sv, input logic [7:0] ev,
      input bit sint, input bit vld, input bit grt, input bit inc);
    return {sv, ev, 11'b0, sint, 1'b0, vld, grt, inc};
  endfunction

  function automatic logic [7:0] svt(input int k);
    case (k)
      0: return 8'd0;
      1: return 8'd100;
      2: return 8'd128;
      default: return 8'd255;
    endcase
  endfunction

  function automatic bit ahd(input logic [7:0] f, input logic [7:0] s);
    logic [7:0] d;
    d = f - s;
    return d < 8'd128;
  endfunction

  initial begin
    #1600000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [7:0] f, sv, ev, expd, fv;
    bit p, inc;
    int w0;

    repeat (3) @(negedge clk);
    chk({flag_wr_en, start, skip, irq, upd_done} == '0, "R11 in reset",
        int'({start, irq}), 0);
    rst_n = 1;
    @(negedge clk);
    chk({flag_wr_en, start, skip, irq, upd_done} == '0, "R11 after reset",
        int'({start, irq}), 0);

    // R2 / R3 / R4 / R5 / R1 sweep
    for (int fi = 0; fi < 256; fi++)
      for (int k = 0; k < 4; k++)
        for (int g = 0; g < 2; g++) begin
          f = 8'(fi); sv = svt(k); ev = ~sv ^ 8'(fi); inc = f[0];
          w = mk(sv, ev, 0, 1, g[0], inc);
          if (f[1]) w = w | 32'h0000_FFE8;   // reserved bits, R1
          @(negedge clk);
          set_en = 1; set_val = f; load[0] = 1; ctl[31:0] = w;
          @(negedge clk);
          set_en = 0; load = '0;
          p = g ? ahd(f, sv) : (f == sv);
          chk(start[0] == p, g ? "R3 compare" : "R2 compare", start[0], p);
          fv = f;
          if (!p) begin
            @(negedge clk);
            chk(start[0] == 0 && !flag_wr_en, "R4 held", start[0], 0);
            set_en = 1; set_val = sv;
            @(negedge clk);
            set_en = 0;
            chk(start[0] == 1, "R4 re-evaluate", start[0], 1);
            fv = sv;
          end
          @(negedge clk);
          done[0] = 1;
          @(negedge clk);
          done[0] = 0;
          expd = inc ? fv + 8'd1 : ev;
          chk(upd_done == 4'b0001 && flag_wr_en && flag_wr_data == expd,
              "R5 write", flag_wr_data, expd);
          @(negedge clk);
          chk(flag == expd && !flag_wr_en, "R5 stored", flag, expd);
        end

    // R7 / R8 sync-interrupt sweep
    for (int fi = 0; fi < 256; fi++)
      for (int k = 0; k < 4; k++) begin
        f = 8'(fi); sv = svt(k);
        w = mk(sv, f ^ 8'h5a, 1, 1, f[1], f[2]);
        @(negedge clk);
        set_en = 1; set_val = f; load[0] = 1; ctl[31:0] = w;
        @(negedge clk);
        set_en = 0; load = '0;
        p = ahd(f, sv);
        chk(irq[0] == p && skip[0] == p, "R7 irq/skip", {irq[0], skip[0]}, {p, p});
        chk(start == '0, "R7 no start", start, 0);
        chk(upd_done == 4'b0001 && flag_wr_data == f + 8'd1, "R8 increment",
            flag_wr_data, f + 8'd1);
        @(negedge clk);
        chk(flag == f + 8'd1 && irq == '0, "R8 stored", flag, f + 8'd1);
      end

    // R6 valid clear, with and without sync bit
    for (int s = 0; s < 2; s++) begin
      f = 8'h33;
      w = mk(8'h99, 8'h44, s[0], 0, 1, 1);
      @(negedge clk);
      set_en = 1; set_val = f; load[0] = 1; ctl[31:0] = w;
      @(negedge clk);
      set_en = 0; load = '0; w0 = n_wr;
      chk(start[0] == 1 && irq == '0, "R6 start", start[0], 1);
      @(negedge clk);
      done[0] = 1;
      @(negedge clk);
      done[0] = 0;
      @(negedge clk);
      chk(n_wr == w0 && flag == f, "R6 no write", n_wr - w0, 0);
    end

    // R10 load ignored while busy
    @(negedge clk);
    set_en = 1; set_val = 8'h10; load[0] = 1; ctl[31:0] = mk(8'h20, 8'h11, 0, 1, 0, 0);
    @(negedge clk);
    set_en = 0; load = '0;
    chk(start[0] == 0, "R10 waiting", start[0], 0);
    load[0] = 1; ctl[31:0] = mk(8'h10, 8'h22, 0, 1, 0, 0);
    @(negedge clk);
    load = '0;
    chk(start[0] == 0, "R10 reload ignored", start[0], 0);
    set_en = 1; set_val = 8'h20;
    @(negedge clk);
    set_en = 0;
    chk(start[0] == 1, "R10 start", start[0], 1);
    @(negedge clk);
    done[0] = 1;
    @(negedge clk);
    done[0] = 0;
    chk(flag_wr_en && flag_wr_data == 8'h11, "R10 first word kept", flag_wr_data, 8'h11);
    @(negedge clk);

    // R9 priority across two sync channels, 128 boundary
    @(negedge clk);
    set_en = 1; set_val = 8'h7f; load = 4'b1010;
    ctl[63:32]   = mk(8'h00, 8'h00, 1, 1, 0, 0);
    ctl[127:96]  = mk(8'h00, 8'h00, 1, 1, 0, 0);
    @(negedge clk);
    set_en = 0; load = '0;
    chk(upd_done == 4'b0010 && flag_wr_data == 8'h80, "R9 low index first",
        upd_done, 4'b0010);
    chk(irq == 4'b0010, "R9 irq ch1", irq, 4'b0010);
    @(negedge clk);
    chk(upd_done == 4'b1000 && flag_wr_data == 8'h81, "R9 second sees update",
        flag_wr_data, 8'h81);
    chk(irq == 4'b0000, "R9 ch3 at 128 boundary", irq, 0);
    @(negedge clk);
    chk(flag == 8'h81 && upd_done == '0, "R9 final flag", flag, 8'h81);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule